// File: doc/BRIEF.md
# Configurable Endpoint Packet Buffer

This block is the byte storage for one data endpoint of a USB device controller. A processor reaches it through one byte-wide data port: each accepted write strobe loads one byte and each accepted read strobe unloads one byte. On the other side, the USB engine has its own byte port. It reads bytes of packets that are waiting to go to the host and writes bytes of packets that arrived from the host. Bytes become packets through commit strobes from the producer and are freed through release strobes from the consumer.

One storage array of `DEPTH` bytes can be set up in two ways. As a unified FIFO, the whole array serves one direction, chosen by `cfg_dir_in`. In split mode it is cut into an IN half and an OUT half. The processor port then writes into the IN half and reads from the OUT half, even though both use the same port. Each FIFO can also be double-buffered. It then holds two packets of half the size and hands them over in ping-pong order. Any change of configuration empties the buffer.

Top module: `ep_fifo`

## Requirements
- R1: After reset, `cpu_rdata` and `usb_rdata` are 0, both packet counts are 0, both full outputs are 0 and both sticky flags are clear.
- R2: In the IN direction, every accepted `cpu_wr` stores one byte. After `cpu_commit`, the USB engine reads the bytes back in write order, and each accepted `usb_rd` updates `usb_rdata` at the next rising edge.
- R3: In the OUT direction, bytes written with `usb_wr` and committed with `usb_commit` are read back in order through `cpu_rd`, and each accepted read updates `cpu_rdata` at the next rising edge.
- R4: With `cfg_split`=1, `cpu_wr` always fills the IN half and `cpu_rd` always drains the OUT half. The two halves keep separate pointers and counts.
- R5: A FIFO holds at most 1 committed packet when single-buffered and 2 when double-buffered. Its full output is 1 while the count equals that limit, and a commit while full is ignored.
- R6: A `cpu_wr` that is rejected (IN FIFO full, current packet at its size limit, or IN direction inactive) stores nothing and sets `cpu_ovr`. The flag stays set until `clr_ovr` is pulsed, and a new rejection in the same cycle as the clear wins.
- R7: A `cpu_rd` that finds no committed unread byte leaves `cpu_rdata` unchanged and sets `cpu_udr`. The flag stays set until `clr_udr` is pulsed.
- R8: A consumer sees only committed bytes. Reads before a commit, or beyond the committed length of the oldest packet, are ignored and leave the read data unchanged.
- R9: A change on any of `cfg_split`, `cfg_dir_in`, `cfg_dbl_in`, `cfg_dbl_out` clears all pointers and packet counts at the first rising edge that sees the new value. Strobes in that cycle are ignored.
- R10: The packet size limit is DEPTH when unified, DEPTH/2 when split, and half of that when double-buffered. With DEPTH=512: 512, 256, 256 (unified double), 128 (split double).
- R11: In double-buffered mode, packets use the two buffers in turn, and each read or write pointer wraps back to the start of its buffer. Packets leave in commit order.
- R12: In unified mode, `cfg_dir_in`=1 makes the whole array an IN FIFO, so a `cpu_rd` is an underrun. `cfg_dir_in`=0 makes it an OUT FIFO, so a `cpu_wr` is an overrun. `cfg_dbl_in` sets double buffering for the unified FIFO in either direction.
- R13: A release frees the oldest committed packet and lowers the count by one. A release with no packet has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_split | input | 1 | 1: split into IN and OUT halves |
| cfg_dir_in | input | 1 | Unified mode direction, 1 = IN |
| cfg_dbl_in | input | 1 | Double buffer for IN half, or for the whole FIFO when unified |
| cfg_dbl_out | input | 1 | Double buffer for OUT half (split mode only) |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | DW | Processor write byte |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_rdata | output | DW | Processor read byte, registered |
| cpu_commit | input | 1 | Commit current IN packet |
| cpu_release | input | 1 | Release oldest OUT packet |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_udr | input | 1 | Clear underrun flag |
| cpu_ovr | output | 1 | Sticky overrun flag |
| cpu_udr | output | 1 | Sticky underrun flag |
| usb_wr | input | 1 | Engine write strobe (OUT data) |
| usb_wdata | input | DW | Engine write byte |
| usb_rd | input | 1 | Engine read strobe (IN data) |
| usb_rdata | output | DW | Engine read byte, registered |
| usb_commit | input | 1 | Commit current OUT packet |
| usb_release | input | 1 | Release oldest IN packet |
| in_pkts | output | 2 | Committed IN packets |
| out_pkts | output | 2 | Committed OUT packets |
| in_full | output | 1 | IN FIFO cannot take another packet |
| out_full | output | 1 | OUT FIFO cannot take another packet |

## Verification
The read data ports change at the rising edge that samples an accepted read strobe. Packet counts, full outputs and sticky flags change at the rising edge that samples their strobe, and a configuration change empties the buffer at the first rising edge that sees it. The bench drives strobes on falling edges. A read task queues its expected byte, and a monitor pops that byte 1 ns after the rising edge that takes the strobe. Status values are checked at the falling edge that follows the strobe's rising edge.

// File: rtl/ep_fifo.sv
module ep_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_split,
  input  logic          cfg_dir_in,
  input  logic          cfg_dbl_in,
  input  logic          cfg_dbl_out,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  input  logic          cpu_commit,
  input  logic          cpu_release,
  input  logic          clr_ovr,
  input  logic          clr_udr,
  output logic          cpu_ovr,
  output logic          cpu_udr,
  input  logic          usb_wr,
  input  logic [DW-1:0] usb_wdata,
  input  logic          usb_rd,
  output logic [DW-1:0] usb_rdata,
  input  logic          usb_commit,
  input  logic          usb_release,
  output logic [1:0]    in_pkts,
  output logic [1:0]    out_pkts,
  output logic          in_full,
  output logic          out_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [3:0] cfg, cfg_q;
  logic       flush;

  logic [1:0] act, dbl, pw, cr, cm, rl;
  logic [1:0] wr_ok, rd_ok, cm_ok, rl_ok, wb, rb;
  logic [1:0]    pk   [2];
  logic [1:0]    nb   [2];
  logic [CW-1:0] bsz  [2];
  logic [CW-1:0] wc   [2];
  logic [CW-1:0] rc   [2];
  logic [CW-1:0] len  [2][2];
  logic [AW-1:0] base [2];
  logic [AW-1:0] wa   [2];
  logic [AW-1:0] ra   [2];

  assign cfg   = {cfg_split, cfg_dir_in, cfg_dbl_in, cfg_dbl_out};
  assign flush = cfg != cfg_q;

  // channel 0 = IN (cpu -> usb), channel 1 = OUT (usb -> cpu)
  assign act = {cfg_split | ~cfg_dir_in, cfg_split | cfg_dir_in};
  assign dbl = {cfg_split ? cfg_dbl_out : cfg_dbl_in, cfg_dbl_in};
  assign pw  = {usb_wr, cpu_wr};
  assign cr  = {cpu_rd, usb_rd};
  assign cm  = {usb_commit, cpu_commit};
  assign rl  = {cpu_release, usb_release};

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      nb[c]    = dbl[c] ? 2'd2 : 2'd1;
      bsz[c]   = (CW'(DEPTH) >> cfg_split) >> dbl[c];
      base[c]  = (c == 1 && cfg_split) ? AW'(DEPTH / 2) : '0;
      wa[c]    = AW'(CW'(base[c]) + (wb[c] ? bsz[c] : '0) + wc[c]);
      ra[c]    = AW'(CW'(base[c]) + (rb[c] ? bsz[c] : '0) + rc[c]);
      wr_ok[c] = act[c] & ~flush & pw[c] & (pk[c] != nb[c]) & (wc[c] != bsz[c]);
      rd_ok[c] = act[c] & ~flush & cr[c] & (pk[c] != 2'd0) & (rc[c] != len[c][rb[c]]);
      cm_ok[c] = act[c] & ~flush & cm[c] & (pk[c] != nb[c]);
      rl_ok[c] = act[c] & ~flush & rl[c] & (pk[c] != 2'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok[0]) mem[wa[0]] <= cpu_wdata;
    if (wr_ok[1]) mem[wa[1]] <= usb_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cpu_rdata <= '0;
      usb_rdata <= '0;
      cpu_ovr   <= 1'b0;
      cpu_udr   <= 1'b0;
      wb        <= '0;
      rb        <= '0;
      for (int c = 0; c < 2; c++) begin
        pk[c]     <= '0;
        wc[c]     <= '0;
        rc[c]     <= '0;
        len[c][0] <= '0;
        len[c][1] <= '0;
      end
    end else begin
      cfg_q <= cfg;
      for (int c = 0; c < 2; c++) begin
        if (flush) begin
          pk[c] <= '0;
          wc[c] <= '0;
          rc[c] <= '0;
          wb[c] <= 1'b0;
          rb[c] <= 1'b0;
        end else begin
          if (wr_ok[c]) wc[c] <= wc[c] + 1'b1;
          if (cm_ok[c]) begin
            len[c][wb[c]] <= wc[c] + CW'(wr_ok[c]);
            wc[c]         <= '0;
            wb[c]         <= dbl[c] & ~wb[c];
          end
          if (rd_ok[c]) rc[c] <= rc[c] + 1'b1;
          if (rl_ok[c]) begin
            rc[c] <= '0;
            rb[c] <= dbl[c] & ~rb[c];
          end
          pk[c] <= pk[c] + 2'(cm_ok[c]) - 2'(rl_ok[c]);
        end
      end
      if (rd_ok[1]) cpu_rdata <= mem[ra[1]];
      if (rd_ok[0]) usb_rdata <= mem[ra[0]];
      if (cpu_wr && !flush && !wr_ok[0]) cpu_ovr <= 1'b1;
      else if (clr_ovr)                  cpu_ovr <= 1'b0;
      if (cpu_rd && !flush && !rd_ok[1]) cpu_udr <= 1'b1;
      else if (clr_udr)                  cpu_udr <= 1'b0;
    end
  end

  assign in_pkts  = pk[0];
  assign out_pkts = pk[1];
  assign in_full  = act[0] & (pk[0] == nb[0]);
  assign out_full = act[1] & (pk[1] == nb[1]);
endmodule

// File: rtl/ep_fifo_chk.sv
module ep_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_split,
  input logic       cfg_dir_in,
  input logic       cfg_dbl_in,
  input logic       cfg_dbl_out,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic       clr_ovr,
  input logic       clr_udr,
  input logic       cpu_ovr,
  input logic       cpu_udr,
  input logic [1:0] in_pkts,
  input logic [1:0] out_pkts,
  input logic       in_full
);
  logic [3:0] cfgv;
  assign cfgv = {cfg_split, cfg_dir_in, cfg_dbl_in, cfg_dbl_out};

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkts <= 2'd2) && (out_pkts <= 2'd2));

  a_r5_single_in: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dbl_in && $stable(cfgv)) |=> (in_pkts <= 2'd1));

  a_r5_single_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_split ? cfg_dbl_out : cfg_dbl_in) && $stable(cfgv)) |=> (out_pkts <= 2'd1));

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfgv) |=> (in_pkts == 2'd0 && out_pkts == 2'd0));

  a_r6_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_full && $stable(cfgv)) |=> cpu_ovr);

  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ovr && !clr_ovr) |=> cpu_ovr);

  a_r7_udr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && out_pkts == 2'd0 && $stable(cfgv)) |=> cpu_udr);

  a_r7_udr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_udr && !clr_udr) |=> cpu_udr);
endmodule

bind ep_fifo ep_fifo_chk u_ep_fifo_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_split(cfg_split), .cfg_dir_in(cfg_dir_in),
  .cfg_dbl_in(cfg_dbl_in), .cfg_dbl_out(cfg_dbl_out),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .clr_ovr(clr_ovr), .clr_udr(clr_udr),
  .cpu_ovr(cpu_ovr), .cpu_udr(cpu_udr),
  .in_pkts(in_pkts), .out_pkts(out_pkts), .in_full(in_full)
);

// File: tb/test_ep_fifo.sv
module test_ep_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_split = 1'b0, cfg_dir_in = 1'b1, cfg_dbl_in = 1'b0, cfg_dbl_out = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_commit = 1'b0, cpu_release = 1'b0;
  logic       clr_ovr = 1'b0, clr_udr = 1'b0;
  logic       usb_wr = 1'b0, usb_rd = 1'b0, usb_commit = 1'b0, usb_release = 1'b0;
  logic [7:0] cpu_wdata = '0, usb_wdata = '0;
  logic [7:0] cpu_rdata, usb_rdata;
  logic       cpu_ovr, cpu_udr, in_full, out_full;
  logic [1:0] in_pkts, out_pkts;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] cq[$], uq[$];
  string      cqt[$], uqt[$];

  always #2 clk = ~clk;

  ep_fifo i_ep_fifo (
    .clk(clk), .rst_n(rst_n),
    .cfg_split(cfg_split), .cfg_dir_in(cfg_dir_in),
    .cfg_dbl_in(cfg_dbl_in), .cfg_dbl_out(cfg_dbl_out),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .cpu_commit(cpu_commit), .cpu_release(cpu_release),
    .clr_ovr(clr_ovr), .clr_udr(clr_udr), .cpu_ovr(cpu_ovr), .cpu_udr(cpu_udr),
    .usb_wr(usb_wr), .usb_wdata(usb_wdata), .usb_rd(usb_rd), .usb_rdata(usb_rdata),
    .usb_commit(usb_commit), .usb_release(usb_release),
    .in_pkts(in_pkts), .out_pkts(out_pkts), .in_full(in_full), .out_full(out_full)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int p, int i);
    return 8'(p * 37 + i * 5 + 1);
  endfunction

  // monitors: read data is due one rising edge after the accepted strobe
  always @(posedge clk) begin
    if (rst_n && cpu_rd) begin
      #1;
      if (cq.size() > 0) chk(cqt.pop_front(), int'(cpu_rdata), int'(cq.pop_front()));
    end
  end
  always @(posedge clk) begin
    if (rst_n && usb_rd) begin
      #1;
      if (uq.size() > 0) chk(uqt.pop_front(), int'(usb_rdata), int'(uq.pop_front()));
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic cpu_put(logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d; tick(); cpu_wr = 1'b0;
  endtask
  task automatic usb_put(logic [7:0] d);
    usb_wr = 1'b1; usb_wdata = d; tick(); usb_wr = 1'b0;
  endtask
  task automatic cpu_get(logic [7:0] exp, string tag);
    cq.push_back(exp); cqt.push_back(tag); cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
  endtask
  task automatic usb_get(logic [7:0] exp, string tag);
    uq.push_back(exp); uqt.push_back(tag); usb_rd = 1'b1; tick(); usb_rd = 1'b0;
  endtask
  task automatic c_commit();  cpu_commit = 1'b1;  tick(); cpu_commit = 1'b0;  endtask
  task automatic u_commit();  usb_commit = 1'b1;  tick(); usb_commit = 1'b0;  endtask
  task automatic c_release(); cpu_release = 1'b1; tick(); cpu_release = 1'b0; endtask
  task automatic u_release(); usb_release = 1'b1; tick(); usb_release = 1'b0; endtask
  task automatic clear_flags(); clr_ovr = 1'b1; clr_udr = 1'b1; tick(); clr_ovr = 1'b0; clr_udr = 1'b0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 cpu_rdata", cpu_rdata, 0);
    chk("R1 usb_rdata", usb_rdata, 0);
    chk("R1 in_pkts", in_pkts, 0);
    chk("R1 out_pkts", out_pkts, 0);
    chk("R1 flags", {cpu_ovr, cpu_udr, in_full, out_full}, 0);

    // unified IN, single buffer
    for (int i = 0; i < 10; i++) cpu_put(pat(1, i));
    usb_get(8'h00, "R8 read before commit");
    c_commit();
    chk("R5 single in_pkts", in_pkts, 1);
    chk("R5 single in_full", in_full, 1);
    cpu_put(8'hEE);
    chk("R6 ovr on full", cpu_ovr, 1);
    c_commit();
    chk("R5 commit while full", in_pkts, 1);
    clr_ovr = 1'b1; tick(); clr_ovr = 1'b0;
    chk("R6 ovr cleared", cpu_ovr, 0);
    cpu_get(8'h00, "R12 cpu read in unified IN");
    chk("R12 udr set", cpu_udr, 1);
    tick();
    chk("R7 udr sticky", cpu_udr, 1);
    clr_udr = 1'b1; tick(); clr_udr = 1'b0;
    chk("R7 udr cleared", cpu_udr, 0);
    for (int i = 0; i < 10; i++) usb_get(pat(1, i), "R2 IN data order");
    usb_get(pat(1, 9), "R8 read past packet end");
    u_release();
    chk("R13 release", in_pkts, 0);
    chk("R13 in_full low", in_full, 0);
    u_release();
    chk("R13 release when empty", in_pkts, 0);

    // R9 flush on direction change
    for (int i = 0; i < 3; i++) cpu_put(pat(9, i));
    c_commit();
    chk("R9 pre-flush", in_pkts, 1);
    cfg_dir_in = 1'b0; tick();
    chk("R9 flushed", in_pkts, 0);

    // unified OUT
    cpu_put(8'h55);
    chk("R12 cpu write in unified OUT", cpu_ovr, 1);
    clear_flags();
    for (int i = 0; i < 6; i++) usb_put(pat(2, i));
    u_commit();
    chk("R3 out_pkts", out_pkts, 1);
    for (int i = 0; i < 6; i++) cpu_get(pat(2, i), "R3 OUT data order");
    cpu_get(pat(2, 5), "R7 read past end keeps data");
    chk("R7 udr past end", cpu_udr, 1);
    c_release();
    chk("R13 out release", out_pkts, 0);
    clear_flags();

    // split, both double buffered: packet limit 128
    cfg_split = 1'b1; cfg_dbl_in = 1'b1; cfg_dbl_out = 1'b1; tick();
    for (int i = 0; i < 128; i++) cpu_put(pat(3, i));
    chk("R10 128 bytes accepted", cpu_ovr, 0);
    cpu_put(8'hAA);
    chk("R10 byte 129 rejected", cpu_ovr, 1);
    clear_flags();
    c_commit();
    for (int i = 0; i < 5; i++) cpu_put(pat(4, i));
    c_commit();
    chk("R5 double in_pkts", in_pkts, 2);
    chk("R5 double in_full", in_full, 1);
    c_commit();
    chk("R5 third commit ignored", in_pkts, 2);
    for (int i = 0; i < 4; i++) usb_put(pat(5, i));
    u_commit();
    chk("R4 out half independent", out_pkts, 1);
    for (int i = 0; i < 4; i++) cpu_get(pat(5, i), "R4 split cpu read from OUT");
    chk("R4 no underrun", cpu_udr, 0);
    c_release();
    for (int i = 0; i < 128; i++) usb_get(pat(3, i), "R11 first buffer");
    u_release();
    chk("R11 one left", in_pkts, 1);
    for (int i = 0; i < 7; i++) cpu_put(pat(6, i));
    c_commit();
    chk("R11 refill", in_pkts, 2);
    for (int i = 0; i < 5; i++) usb_get(pat(4, i), "R11 second buffer");
    u_release();
    for (int i = 0; i < 7; i++) usb_get(pat(6, i), "R11 wrapped to first buffer");
    u_release();
    chk("R11 drained", in_pkts, 0);

    // split, single buffered: packet limit 256
    cfg_dbl_in = 1'b0; cfg_dbl_out = 1'b0; tick();
    for (int i = 0; i < 256; i++) cpu_put(pat(7, i));
    chk("R10 256 bytes accepted", cpu_ovr, 0);
    cpu_put(8'hBB);
    chk("R10 byte 257 rejected", cpu_ovr, 1);
    c_commit();
    c_commit();
    chk("R5 split single count", in_pkts, 1);
    for (int i = 0; i < 256; i++) usb_get(pat(7, i), "R10 split single data");
    u_release();
    chk("R13 split release", in_pkts, 0);

    repeat (3) tick();
    finish_run();
  end
endmodule